// File: doc/BRIEF.md
# Sample Input Formatter with Crossbar and Zero Stuffing

This block sits at the front of a four-channel receive path. It takes a bank of parallel sample lanes and hands one 16-bit sample stream to each of four down-converter channels. In narrow mode there are four independent sources, each 14 bits wide. In wide mode there are three independent sources, each 16 bits wide. Every channel has its own 2-bit source select, so the four channels together form a crossbar: any source can feed any channel, and one source can feed several channels.

When the sample rate equals the clock rate, a fresh sample is taken on every clock. For slower inputs a pad count N (0 to 15) is set. Each real sample is then followed by exactly N zero samples, which gives a period of N+1 clocks. Each output slot carries a per-channel valid strobe. A common start flag marks the slot that holds a real sample. Configuration is held for a whole period, so a period is never cut short.

Top module: `fmt_input_formatter`

## Requirements
- R1: While reset is asserted and on the first clock after it, `ch_data` is all zero, `ch_valid` is all zero and `sample_start` is low.
- R2: Narrow mode (`wide_mode`=0) has four sources. Source k is bits [16k+13:16k] of `in_lanes`. It is output left-justified as {source,2'b00}, and lane bits [16k+15:16k+14] have no effect.
- R3: Wide mode (`wide_mode`=1) has three sources. Source k is the full 16 bits [16k+15:16k] of `in_lanes`, for k=0..2. A channel whose select is 3 outputs zero with its valid low, and lane 3 has no effect.
- R4: Channel c takes its source from `src_sel[2c+1:2c]`. Channel c's output is `ch_data[16c+15:16c]`. Every select value works on every channel at the same time.
- R5: With a pad count of 0, every slot carries a real sample and `sample_start` is high on every slot.
- R6: With a pad count of N, each real-sample slot is followed by exactly N slots of zero data with `sample_start` low. Lane inputs presented during those N clocks have no effect.
- R7: The pad count, the selects and the mode are sampled only on the first clock of a period. Changes made during the other clocks take effect only at the next period boundary.
- R8: A real sample presented on the first clock of a period appears on the outputs after exactly one clock edge.
- R9: From the first slot after reset, `ch_valid[c]` is high on every slot, real or padded, unless channel c selects the unused source in wide mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 0: four 14-bit sources, 1: three 16-bit sources |
| pad_count | input | 4 | Number of zero slots inserted after each real sample |
| src_sel | input | 8 | Per-channel source select, 2 bits per channel |
| in_lanes | input | 64 | Four 16-bit input lanes |
| ch_data | output | 64 | Four 16-bit channel outputs |
| ch_valid | output | 4 | Per-channel slot valid |
| sample_start | output | 1 | High on the slot that carries a real sample |

## Verification
Every output is a register. A real sample, and the configuration that shapes it, is therefore due exactly one edge after the first clock of its period, and a padded slot is due one edge after its own clock. The bench drives inputs on the falling edge. It forms the expected slot from a countdown model of the period, and it compares all outputs on the next falling edge, one clock after the stimulus. Configuration changes are also made in the middle of periods, and lane data changes on every clock, so that sampling off the period boundary shows up as a mismatch.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

    typedef enum logic {
        FMT_NARROW = 1'b0,
        FMT_WIDE   = 1'b1
    } fmt_mode_e;

endpackage

// File: rtl/fmt_pad_timer.sv
module fmt_pad_timer #(
    parameter int NUM_CH = 4,
    parameter int SEL_W  = 2,
    parameter int PAD_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PAD_W-1:0]          pad_in,
    input  logic [NUM_CH*SEL_W-1:0]   sel_in,
    input  logic                      wide_in,
    output logic                      boundary,
    output logic [NUM_CH*SEL_W-1:0]   sel_eff,
    output logic                      wide_eff
);

    typedef struct packed {
        logic [PAD_W-1:0]        cnt;
        logic [PAD_W-1:0]        pad;
        logic [NUM_CH*SEL_W-1:0] sel;
        logic                    wide;
    } timer_state_t;

    timer_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        boundary = (st_q.cnt == '0);
        sel_eff  = boundary ? sel_in  : st_q.sel;
        wide_eff = boundary ? wide_in : st_q.wide;
        if (boundary) begin
            st_d.pad  = pad_in;
            st_d.sel  = sel_in;
            st_d.wide = wide_in;
            st_d.cnt  = (pad_in == '0) ? '0 : PAD_W'(1);
        end else if (st_q.cnt == st_q.pad) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + PAD_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: the phase counter never runs past the latched pad count
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.pad);

    // R7: latched configuration holds through the inside of a period
    a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |=> ($stable(st_q.sel) && $stable(st_q.pad) && $stable(st_q.wide)));

endmodule

// File: rtl/fmt_xbar.sv
module fmt_xbar
    import fmt_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int NUM_LANE = 4,
    parameter int NUM_WIDE = 3,
    parameter int OUT_W    = 16,
    parameter int NARROW_W = 14,
    parameter int SEL_W    = 2
) (
    input  logic [NUM_LANE*OUT_W-1:0] in_lanes,
    input  logic [NUM_CH*SEL_W-1:0]   sel_eff,
    input  logic                      wide_eff,
    output logic [NUM_CH*OUT_W-1:0]   routed,
    output logic [NUM_CH-1:0]         used
);

    localparam int JUST_W = OUT_W - NARROW_W;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [SEL_W-1:0] s;
        logic [OUT_W-1:0] lane;
        always_comb begin
            s    = sel_eff[c*SEL_W +: SEL_W];
            lane = in_lanes[int'(s)*OUT_W +: OUT_W];
            if (fmt_mode_e'(wide_eff) == FMT_WIDE) begin
                used[c] = (int'(s) < NUM_WIDE);
                routed[c*OUT_W +: OUT_W] = used[c] ? lane : '0;
            end else begin
                used[c] = 1'b1;
                routed[c*OUT_W +: OUT_W] = {lane[NARROW_W-1:0], {JUST_W{1'b0}}};
            end
        end
    end

endmodule

// File: rtl/fmt_input_formatter.sv
module fmt_input_formatter #(
    parameter int NUM_CH   = 4,
    parameter int NUM_LANE = 4,
    parameter int NUM_WIDE = 3,
    parameter int OUT_W    = 16,
    parameter int NARROW_W = 14,
    parameter int SEL_W    = 2,
    parameter int PAD_W    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wide_mode,
    input  logic [PAD_W-1:0]          pad_count,
    input  logic [NUM_CH*SEL_W-1:0]   src_sel,
    input  logic [NUM_LANE*OUT_W-1:0] in_lanes,
    output logic [NUM_CH*OUT_W-1:0]   ch_data,
    output logic [NUM_CH-1:0]         ch_valid,
    output logic                      sample_start
);

    typedef struct packed {
        logic [NUM_CH*OUT_W-1:0] data;
        logic [NUM_CH-1:0]       valid;
        logic                    start;
    } out_state_t;

    out_state_t os_d, os_q;

    logic                    boundary;
    logic [NUM_CH*SEL_W-1:0] sel_eff;
    logic                    wide_eff;
    logic [NUM_CH*OUT_W-1:0] routed;
    logic [NUM_CH-1:0]       used;

    fmt_pad_timer #(
        .NUM_CH (NUM_CH),
        .SEL_W  (SEL_W),
        .PAD_W  (PAD_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_count),
        .sel_in   (src_sel),
        .wide_in  (wide_mode),
        .boundary (boundary),
        .sel_eff  (sel_eff),
        .wide_eff (wide_eff)
    );

    fmt_xbar #(
        .NUM_CH   (NUM_CH),
        .NUM_LANE (NUM_LANE),
        .NUM_WIDE (NUM_WIDE),
        .OUT_W    (OUT_W),
        .NARROW_W (NARROW_W),
        .SEL_W    (SEL_W)
    ) u_xbar (
        .in_lanes (in_lanes),
        .sel_eff  (sel_eff),
        .wide_eff (wide_eff),
        .routed   (routed),
        .used     (used)
    );

    always_comb begin
        os_d.data  = boundary ? routed : '0;
        os_d.valid = used;
        os_d.start = boundary;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            os_q <= '0;
        end else begin
            os_q <= os_d;
        end
    end

    assign ch_data      = os_q.data;
    assign ch_valid     = os_q.valid;
    assign sample_start = os_q.start;

    // R6: padded slots carry zero data on every channel
    a_r6_pad_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_start |-> (ch_data == '0));

    // R5: a period opened with a zero pad count is followed by another real slot
    a_r5_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_start && ($past(pad_count) == '0) && $past(boundary)) |=> sample_start);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R3: a channel without a source stays at zero
        a_r3_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_valid[c] |-> (ch_data[c*OUT_W +: OUT_W] == '0));
    end

endmodule

// File: tb/fmt_input_formatter_test.sv
module fmt_input_formatter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic [3:0]  pad_count = '0;
    logic [7:0]  src_sel = '0;
    logic [63:0] in_lanes = '0;
    logic [63:0] ch_data;
    logic [3:0]  ch_valid;
    logic        sample_start;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;
    string tag_override = "";

    // bench model of the period: remaining pad slots and latched config
    int         m_rem = 0;
    logic [7:0] m_sel = '0;
    logic       m_wide = 1'b0;

    always #5 clk = ~clk;

    fmt_input_formatter uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wide_mode    (wide_mode),
        .pad_count    (pad_count),
        .src_sel      (src_sel),
        .in_lanes     (in_lanes),
        .ch_data      (ch_data),
        .ch_valid     (ch_valid),
        .sample_start (sample_start)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    function automatic logic [63:0] lane_pattern(input int n);
        logic [63:0] v;
        for (int k = 0; k < 4; k++) begin
            v[k*16 +: 16] = 16'((n * 40503) ^ (k * 6997) ^ (n << 9));
        end
        return v;
    endfunction

    // one clock: drive at falling edge, compare one edge later
    task automatic step();
        logic [63:0] e_data;
        logic [3:0]  e_valid;
        logic        e_start;
        int          s;
        string       t;
        in_lanes = lane_pattern(cyc);
        e_start  = (m_rem == 0);
        if (e_start) begin
            m_sel  = src_sel;
            m_wide = wide_mode;
            m_rem  = int'(pad_count);
        end else begin
            m_rem--;
        end
        for (int c = 0; c < 4; c++) begin
            s = int'(m_sel[c*2 +: 2]);
            e_valid[c] = !(m_wide && s == 3);
            if (!e_start || !e_valid[c]) e_data[c*16 +: 16] = '0;
            else if (m_wide)             e_data[c*16 +: 16] = in_lanes[s*16 +: 16];
            else                         e_data[c*16 +: 16] = {in_lanes[s*16 +: 14], 2'b00};
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
        if (tag_override != "") t = tag_override;
        else if (!e_start) t = "R6";
        else if (m_wide) t = "R3";
        else t = "R2";
        check({t, "/R4 data"}, ch_data, e_data);
        check("R9 valid", {60'd0, ch_valid}, {60'd0, e_valid});
        check((pad_count == 0) ? "R5 start" : "R6 start", {63'd0, sample_start}, {63'd0, e_start});
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset data", ch_data, '0);
        check("R1 reset valid", {60'd0, ch_valid}, '0);
        check("R1 reset start", {63'd0, sample_start}, '0);
        rst_n = 1'b1;

        // R8: a value presented at a boundary is on the outputs one edge later
        tag_override = "R8";
        pad_count = 4'd0; src_sel = 8'b11_10_01_00; wide_mode = 1'b0;
        for (int i = 0; i < 4; i++) step();
        tag_override = "";

        // R2, R3, R4, R5: every select combination at full rate in both modes
        for (int w = 0; w < 2; w++) begin
            for (int sv = 0; sv < 256; sv++) begin
                wide_mode = w[0];
                src_sel = 8'(sv);
                step();
            end
        end

        // R6: pad counts across the range, selects changing mid-period
        for (int w = 0; w < 2; w++) begin
            for (int p = 0; p < 16; p++) begin
                pad_count = 4'(p);
                for (int i = 0; i < 3 * (p + 1) + 2; i++) begin
                    if (i % 5 == 3) src_sel = src_sel + 8'd37;
                    if (i == p + 2) wide_mode = ~wide_mode;
                    wide_mode = (i > p + 2) ? ~w[0] : w[0];
                    step();
                end
            end
        end

        // R7: pad count and selects changed inside a period wait for the boundary
        tag_override = "R7";
        pad_count = 4'd7; wide_mode = 1'b1; src_sel = 8'b00_01_10_00;
        while (m_rem != 0) step();
        step();
        pad_count = 4'd0; src_sel = 8'b10_10_10_10; wide_mode = 1'b0;
        for (int i = 0; i < 12; i++) step();
        pad_count = 4'd15;
        step();
        pad_count = 4'd2; src_sel = 8'b01_11_00_10; wide_mode = 1'b1;
        for (int i = 0; i < 30; i++) step();
        tag_override = "";

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule